// File: doc/BRIEF.md
# Bitwise Logic Unit with Selectable Second Operand

This block is the combinational logic execution unit of a small processor datapath. It takes a first operand from a register. The second operand comes from one of three sources: a plain register value, a value already shifted by the external shifter, or a zero-extended immediate. A 2-bit opcode picks one of four operations: AND, bit clear (first operand AND the inverse of the second), OR, or exclusive-OR. Every operation is strictly bitwise, so result bit i depends only on bit i of each operand.

Along with the result, the unit produces a negative flag and a zero flag, and it passes the shifter's carry-out straight through as the carry flag. It has no clock and no reset. Arithmetic, register-file access and the shifter itself sit outside this block.

Top module: `bitlogic_unit`

## Requirements
- R1: With opcode 00 (AND), result bit i is 1 only when both operand bits i are 1; 0xB6A43D9A AND 0x000000FF gives 0x0000009A.
- R2: With opcode 01 (bit clear), the result is op1 AND NOT op2; 0xB6A43D9A with mask 0x000000FF gives 0xB6A43D00.
- R3: With opcode 10 (OR), every bit set in op2 is forced to 1; 0x12345678 OR 0x0000FFFF gives 0x1234FFFF.
- R4: With opcode 11 (exclusive-OR), every bit set in op2 is inverted; 0x12345678 XOR 0x0000FFFF gives 0x1234A987.
- R5: Operand select 00 takes op2 from the plain register input `reg_b_i`.
- R6: Operand select 01 takes op2 from the shifted-register input `shifted_b_i`.
- R7: Operand select 10 takes op2 from `imm_i` zero-extended to the data width, so op2 bits at IMM_W and above are 0.
- R8: Operand select 11 is treated like 00 and takes op2 from `reg_b_i`.
- R9: The N flag equals result bit 31 (the top bit).
- R10: The Z flag is 1 exactly when all bits of the result are 0.
- R11: The C flag equals `shift_carry_i` for every opcode and every operand select.
- R12: Inverting one bit i of op1 changes only bit i of the result, if it changes any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op1_i | input | 32 | First operand, taken from a register |
| reg_b_i | input | 32 | Plain register candidate for the second operand |
| shifted_b_i | input | 32 | Shifted register candidate for the second operand, supplied by the shifter |
| shift_carry_i | input | 1 | Carry-out of the shifter |
| imm_i | input | 12 | Immediate candidate for the second operand, zero-extended |
| opsel_i | input | 2 | Source of the second operand: 00 register, 01 shifted, 10 immediate, 11 register |
| opcode_i | input | 2 | Operation: 00 AND, 01 bit clear, 10 OR, 11 exclusive-OR |
| result_o | output | 32 | Result of the operation |
| flag_n_o | output | 1 | Negative flag, the top bit of the result |
| flag_z_o | output | 1 | Zero flag, set when the result is all zeros |
| flag_c_o | output | 1 | Carry flag, the shifter carry passed through |

## Verification
The assertions are immediate checks that run whenever the inputs change. Each one is skipped while any input it reads is unknown, so it assumes known, two-valued operands, opcode and select. The bench drives every input to a defined value in each step, starting with the first, and changes the whole input set at once, a fixed delay after the clock edge. The design outputs are therefore settled when the monitor reads them half a period later.

// File: rtl/bitlogic_pkg.sv
package bitlogic_pkg;

    localparam int DATA_W = 32;
    localparam int IMM_W  = 12;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_BIC = 2'b01,
        OP_ORR = 2'b10,
        OP_EOR = 2'b11
    } logic_op_e;

    typedef enum logic [1:0] {
        SRC_REG   = 2'b00,
        SRC_SHIFT = 2'b01,
        SRC_IMM   = 2'b10,
        SRC_ALT   = 2'b11
    } opnd_src_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
    } flags_t;

    function automatic logic lane_op(input logic_op_e op, input logic a, input logic b);
        logic r;
        case (op)
            OP_AND:  r = a & b;
            OP_BIC:  r = a & ~b;
            OP_ORR:  r = a | b;
            default: r = a ^ b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/blu_operand_sel.sv
module blu_operand_sel
    import bitlogic_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IMM_W
) (
    input  logic [W-1:0]  reg_b,
    input  logic [W-1:0]  shifted_b,
    input  logic [IW-1:0] imm,
    input  opnd_src_e     src,
    output logic [W-1:0]  op2
);
    localparam int PAD_W = W - IW;

    logic [W-1:0] imm_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign imm_ext = {{PAD_W{1'b0}}, imm};
        end else begin : g_nopad
            assign imm_ext = imm[W-1:0];
        end
    endgenerate

    always_comb begin
        case (src)
            SRC_SHIFT: op2 = shifted_b;
            SRC_IMM:   op2 = imm_ext;
            default:   op2 = reg_b;
        endcase
    end

    always_comb begin
        if (!$isunknown({src, imm}) && src == SRC_IMM) begin
            assert_imm_zero_ext_R7: assert ((op2 >> IW) == '0 && op2[IW-1:0] == imm)
                else $error("immediate operand not zero-extended");
        end
        if (!$isunknown({src, reg_b}) && (src == SRC_REG || src == SRC_ALT)) begin
            assert_reg_source_R8: assert (op2 == reg_b)
                else $error("register operand not selected");
        end
    end
endmodule

// File: rtl/blu_bitop_core.sv
module blu_bitop_core
    import bitlogic_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_op_e    op,
    output logic [W-1:0] y
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_lane
            always_comb y[i] = lane_op(op, a[i], b[i]);
        end
    endgenerate

    always_comb begin
        if (!$isunknown({a, b, op})) begin
            if (op == OP_AND || op == OP_BIC) begin
                assert_and_subset_R1: assert ((y & ~a) == '0)
                    else $error("and-type result sets bit absent in op1");
            end
            if (op == OP_BIC) begin
                assert_bic_clears_R2: assert ((y & b) == '0)
                    else $error("bit clear left a masked bit set");
            end
            if (op == OP_ORR) begin
                assert_or_forces_R3: assert ((y & b) == b && (y & ~b) == (a & ~b))
                    else $error("or result wrong");
            end
            if (op == OP_EOR) begin
                assert_eor_inverts_R4: assert ((y ^ b) == a)
                    else $error("exclusive-or result wrong");
            end
        end
    end
endmodule

// File: rtl/blu_flag_gen.sv
module blu_flag_gen
    import bitlogic_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] res,
    input  logic         carry_in,
    output flags_t       flags
);
    always_comb begin
        flags.neg   = res[W-1];
        flags.zero  = ~|res;
        flags.carry = carry_in;
    end
endmodule

// File: rtl/bitlogic_unit.sv
module bitlogic_unit
    import bitlogic_pkg::*;
(
    input  logic [DATA_W-1:0] op1_i,
    input  logic [DATA_W-1:0] reg_b_i,
    input  logic [DATA_W-1:0] shifted_b_i,
    input  logic              shift_carry_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [1:0]        opsel_i,
    input  logic [1:0]        opcode_i,
    output logic [DATA_W-1:0] result_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_c_o
);
    logic [DATA_W-1:0] op2;
    logic [DATA_W-1:0] res;
    flags_t            flg;
    opnd_src_e         src;
    logic_op_e         op;

    assign src = opnd_src_e'(opsel_i);
    assign op  = logic_op_e'(opcode_i);

    blu_operand_sel #(.W(DATA_W), .IW(IMM_W)) u_sel (
        .reg_b     (reg_b_i),
        .shifted_b (shifted_b_i),
        .imm       (imm_i),
        .src       (src),
        .op2       (op2)
    );

    blu_bitop_core #(.W(DATA_W)) u_core (
        .a  (op1_i),
        .b  (op2),
        .op (op),
        .y  (res)
    );

    blu_flag_gen #(.W(DATA_W)) u_flags (
        .res      (res),
        .carry_in (shift_carry_i),
        .flags    (flg)
    );

    assign result_o = res;
    assign flag_n_o = flg.neg;
    assign flag_z_o = flg.zero;
    assign flag_c_o = flg.carry;

    always_comb begin
        if (!$isunknown({op1_i, reg_b_i, shifted_b_i, imm_i, opsel_i, opcode_i, shift_carry_i})) begin
            assert_neg_flag_R9: assert (flag_n_o == result_o[DATA_W-1])
                else $error("N flag mismatch");
            assert_zero_flag_R10: assert (flag_z_o == (result_o == '0))
                else $error("Z flag mismatch");
            assert_carry_pass_R11: assert (flag_c_o == shift_carry_i)
                else $error("C flag mismatch");
            if (opsel_i == 2'b01 && opcode_i == 2'b11) begin
                assert_shift_source_R6: assert ((result_o ^ op1_i) == shifted_b_i)
                    else $error("shifted operand not used");
            end
        end
    end
endmodule

// File: tb/test_bitlogic_unit.sv
module test_bitlogic_unit;
    logic [31:0] op1, regb, shb;
    logic        cin;
    logic [11:0] imm;
    logic [1:0]  opsel, opcode;
    logic [31:0] res;
    logic        fn, fz, fc;
    logic        clk = 1'b0;

    always #5 clk = ~clk;

    bitlogic_unit i_bitlogic_unit (
        .op1_i(op1), .reg_b_i(regb), .shifted_b_i(shb), .shift_carry_i(cin),
        .imm_i(imm), .opsel_i(opsel), .opcode_i(opcode),
        .result_o(res), .flag_n_o(fn), .flag_z_o(fz), .flag_c_o(fc)
    );

    typedef struct {
        logic [31:0] r;
        logic        n, z, c;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    function automatic logic [31:0] ref_op2(logic [1:0] s, logic [31:0] rb, logic [31:0] sb, logic [11:0] im);
        case (s)
            2'b01:   return sb;
            2'b10:   return {20'd0, im};
            default: return rb;
        endcase
    endfunction

    function automatic logic [31:0] ref_res(logic [1:0] oc, logic [31:0] a, logic [31:0] b);
        case (oc)
            2'b00:   return a & b;
            2'b01:   return a & ~b;
            2'b10:   return a | b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic drive(input logic [1:0] oc, input logic [1:0] s, input logic [31:0] a,
                         input logic [31:0] rb, input logic [31:0] sb, input logic [11:0] im,
                         input logic c, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        op1 = a; regb = rb; shb = sb; imm = im; opsel = s; opcode = oc; cin = c;
        e.r   = ref_res(oc, a, ref_op2(s, rb, sb, im));
        e.n   = e.r[31];
        e.z   = (e.r == 32'd0);
        e.c   = c;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.tag, " result"}, res, e.r);
            chk("R9 N flag", {31'd0, fn}, {31'd0, e.n});
            chk("R10 Z flag", {31'd0, fz}, {31'd0, e.z});
            chk("R11 C flag", {31'd0, fc}, {31'd0, e.c});
        end
    end

    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] base;
        logic [31:0] flip;
        op1 = '0; regb = '0; shb = '0; imm = '0; opsel = '0; opcode = '0; cin = 0;
        drive(2'b00, 2'b00, 32'h0, 32'h0, 32'h0, 12'h0, 1'b0, "R10 all-zero start");
        // fixed values from the requirements
        drive(2'b00, 2'b00, 32'hB6A43D9A, 32'h000000FF, 32'hDEADBEEF, 12'h0, 1'b0, "R1 and mask");
        drive(2'b01, 2'b00, 32'hB6A43D9A, 32'h000000FF, 32'h0, 12'h0, 1'b1, "R2 bic mask");
        drive(2'b10, 2'b00, 32'h12345678, 32'h0000FFFF, 32'h0, 12'h0, 1'b0, "R3 or force");
        drive(2'b11, 2'b00, 32'h12345678, 32'h0000FFFF, 32'h0, 12'h0, 1'b1, "R4 eor invert");
        drive(2'b00, 2'b00, 32'h00000D00, 32'h00003C00, 32'h0, 12'h0, 1'b0, "R1 and pair");
        drive(2'b01, 2'b00, 32'h002C0D00, 32'h00083C00, 32'h0, 12'h0, 1'b0, "R2 bic pair");
        drive(2'b10, 2'b00, 32'h00000D00, 32'h00003C00, 32'h0, 12'h0, 1'b0, "R3 or pair");
        drive(2'b11, 2'b00, 32'h00000D00, 32'h00003C00, 32'h0, 12'h0, 1'b0, "R4 eor pair");
        // operand sources
        drive(2'b11, 2'b00, 32'h0F0F0F0F, 32'h11111111, 32'h22222222, 12'h333, 1'b0, "R5 register source");
        drive(2'b11, 2'b01, 32'h0F0F0F0F, 32'h11111111, 32'h22222222, 12'h333, 1'b1, "R6 shifted source");
        drive(2'b10, 2'b10, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 12'hFFF, 1'b0, "R7 immediate zero-ext");
        drive(2'b01, 2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 12'hABC, 1'b1, "R7 immediate bic");
        drive(2'b11, 2'b11, 32'h0F0F0F0F, 32'h11111111, 32'h22222222, 12'h333, 1'b0, "R8 alt select");
        // flags
        drive(2'b10, 2'b00, 32'h80000000, 32'h00000000, 32'h0, 12'h0, 1'b0, "R9 negative result");
        drive(2'b11, 2'b00, 32'hCAFEF00D, 32'hCAFEF00D, 32'h0, 12'h0, 1'b1, "R10 zero by eor");
        drive(2'b01, 2'b01, 32'h12345678, 32'h0, 32'hFFFFFFFF, 12'h0, 1'b1, "R10 zero by bic");
        for (int oc = 0; oc < 4; oc++) begin
            for (int s = 0; s < 4; s++) begin
                drive(oc[1:0], s[1:0], 32'hA5A5F00F, 32'h3C3C3C3C, 32'hFF00FF00, 12'h5A5,
                      oc[0] ^ s[1], "R11 opcode/select sweep");
            end
        end
        // bit independence: flip one op1 bit, compare with base result
        for (int oc = 0; oc < 4; oc++) begin
            for (int b = 0; b < 32; b += 7) begin
                drive(oc[1:0], 2'b00, 32'h6B3D19E4, 32'h5C96A3F1, 32'h0, 12'h0, 1'b0, "R12 base");
                @(negedge clk);
                #1;
                base = res;
                drive(oc[1:0], 2'b00, 32'h6B3D19E4 ^ (32'd1 << b), 32'h5C96A3F1, 32'h0, 12'h0, 1'b0, "R12 flipped");
                @(negedge clk);
                #1;
                flip = res;
                chk("R12 other bits unchanged", (base ^ flip) & ~(32'd1 << b), 32'h0);
            end
        end
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule